// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 32-bit physical address. Memory is split into 4 KB pages, and the mapping lives in a two-level tree of tables. The walker reads one entry from the top-level table. That entry points to a second-level table, and the walker reads one entry from it. It uses a single 32-bit memory read port for both reads, and that port may take any number of cycles to answer. If the entry read at either level is marked absent, the walker raises a page fault and issues no physical address.

A request is taken on `req_valid` while `req_ready` is high. When the enable input is clear at that moment, the walker skips both reads and returns the linear address unchanged one cycle later. Every request ends with exactly one `done` pulse. On that pulse, either `phys_addr` holds the translation, or `fault` is set along with the fault vector, the level that faulted and the linear address that faulted.

Top module: `pgwalk_top`

## Requirements
- R1: While reset is held and right after it, `done`, `fault` and `mem_req` are 0 and `req_ready` is 1.
- R2: A request accepted with `pg_en`=0 gives `done`=1 in the next cycle with `phys_addr` equal to the request's linear address and `fault`=0, and `mem_req` stays low for the whole request.
- R3: The first read goes to the root table entry: bits 31:12 come from the root base, bits 11:2 are linear bits 31:22, and bits 1:0 are 0.
- R4: The second read goes to the leaf table entry: bits 31:12 come from root entry bits 31:12, bits 11:2 are linear bits 21:12, and bits 1:0 are 0.
- R5: When both entries have bit 0 (present) set, `phys_addr` is leaf entry bits 31:12 joined with linear bits 11:0, and `fault`=0. All other entry bits are ignored.
- R6: If the root entry has bit 0 clear, the request ends with `fault`=1, `fault_code`=0x0E, `fault_level`=0, `fault_lin` set to the linear address and `phys_addr`=0, and no second read is made.
- R7: If the leaf entry has bit 0 clear, the request ends with `fault`=1, `fault_code`=0x0E, `fault_level`=1, `fault_lin` set to the linear address and `phys_addr`=0.
- R8: Each request gives exactly one single-cycle `done` pulse. `req_ready` is low from acceptance until that pulse, and `fault` is only high together with `done`.
- R9: The linear address, root base and enable bit are captured when the request is accepted. Changes to them while the walk is running have no effect.
- R10: A read is held (`mem_req` high, `mem_addr` stable) until `mem_rvalid` answers it, whatever the latency. With a latency of L cycles per read, a full walk ends 2L+2 cycles after acceptance and a root fault ends L+1 cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_lin | input | 32 | Linear address to translate |
| dir_base | input | 32 | Root table base, bits 31:12 used |
| pg_en | input | 1 | Translation enable; 0 passes the address through |
| mem_req | output | 1 | Entry read request, held until answered |
| mem_addr | output | 32 | Entry read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read entry |
| done | output | 1 | One-cycle completion pulse |
| phys_addr | output | 32 | Physical address, 0 on a fault |
| fault | output | 1 | Page fault, only with done |
| fault_code | output | 8 | Fault vector 0x0E on a fault, else 0 |
| fault_level | output | 1 | 0 root level, 1 leaf level |
| fault_lin | output | 32 | Linear address that faulted |

## Verification
The assertions check several rules on every cycle. `done` never lasts two cycles, a fault never appears without `done`, and a fault never carries a physical address. A pending read keeps its address until it is answered. The pass-through path answers in the following cycle with the captured address, and an absent root entry ends the walk as a level-0 fault. The bench scenarios are needed for the rest: the exact entry addresses built from the index fields, the final address assembled from the leaf frame, the completion cycle under different memory latencies, the leaf-level fault, and the fact that inputs changed during a walk are ignored.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  localparam int VA_W    = 32;
  localparam int OFF_W   = 12;
  localparam int IDX_W   = 10;
  localparam int ENT_LSB = 2;
  localparam int FRM_W   = VA_W - OFF_W;

  typedef logic [VA_W-1:0] addr_t;
  typedef enum logic [1:0] {ST_IDLE, ST_ROOT, ST_LEAF} walk_st_t;

  function automatic addr_t root_ent_addr(addr_t base, addr_t lin);
    return {base[VA_W-1:OFF_W], lin[VA_W-1 -: IDX_W], {ENT_LSB{1'b0}}};
  endfunction

  function automatic addr_t leaf_ent_addr(addr_t pde, addr_t lin);
    return {pde[VA_W-1:OFF_W], lin[OFF_W+IDX_W-1 -: IDX_W], {ENT_LSB{1'b0}}};
  endfunction

  function automatic addr_t frame_join(addr_t pte, addr_t lin);
    return {pte[VA_W-1:OFF_W], lin[OFF_W-1:0]};
  endfunction

  function automatic logic ent_present(addr_t ent);
    return ent[0];
  endfunction
endpackage

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid,
  input  logic     pg_en,
  input  logic     mem_rvalid,
  input  logic     rsp_present,
  output walk_st_t st,
  output logic     ev_accept,
  output logic     ev_bypass,
  output logic     ev_root_rsp,
  output logic     ev_leaf_rsp
);
  walk_st_t st_nx;

  assign ev_accept   = req_valid && (st == ST_IDLE);
  assign ev_bypass   = ev_accept && !pg_en;
  assign ev_root_rsp = (st == ST_ROOT) && mem_rvalid;
  assign ev_leaf_rsp = (st == ST_LEAF) && mem_rvalid;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE: if (ev_accept && pg_en) st_nx = ST_ROOT;
      ST_ROOT: if (ev_root_rsp) st_nx = rsp_present ? ST_LEAF : ST_IDLE;
      ST_LEAF: if (ev_leaf_rsp) st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  // R6: an absent root entry never leads to a leaf read
  p_no_leaf_after_absent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_root_rsp && !rsp_present |=> st == ST_IDLE);
endmodule

// File: rtl/pgwalk_dpath.sv
module pgwalk_dpath
  import pgwalk_pkg::*;
#(
  parameter logic [7:0] FAULT_VEC = 8'h0E
) (
  input  logic     clk,
  input  logic     rst_n,
  input  walk_st_t st,
  input  logic     ev_accept,
  input  logic     ev_bypass,
  input  logic     ev_root_rsp,
  input  logic     ev_leaf_rsp,
  input  addr_t    req_lin,
  input  addr_t    dir_base,
  input  addr_t    mem_rdata,
  output addr_t    mem_addr,
  output logic     done,
  output addr_t    phys_addr,
  output logic     fault,
  output logic [7:0] fault_code,
  output logic     fault_level,
  output addr_t    fault_lin
);
  addr_t lin_q, base_q, pde_q;
  logic  rsp_ok;
  logic  ev_fault;

  assign rsp_ok   = ent_present(mem_rdata);
  assign ev_fault = (ev_root_rsp || ev_leaf_rsp) && !rsp_ok;
  assign mem_addr = (st == ST_LEAF) ? leaf_ent_addr(pde_q, lin_q)
                                    : root_ent_addr(base_q, lin_q);
  assign fault_code = fault ? FAULT_VEC : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lin_q <= '0; base_q <= '0; pde_q <= '0;
    end else begin
      if (ev_accept) begin
        lin_q  <= req_lin;
        base_q <= dir_base;
      end
      if (ev_root_rsp) pde_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done <= 1'b0; fault <= 1'b0; phys_addr <= '0;
      fault_level <= 1'b0; fault_lin <= '0;
    end else begin
      done  <= ev_bypass || ev_leaf_rsp || (ev_root_rsp && !rsp_ok);
      fault <= ev_fault;
      if (ev_bypass) phys_addr <= req_lin;
      else if (ev_fault) begin
        phys_addr   <= '0;
        fault_level <= ev_leaf_rsp;
        fault_lin   <= lin_q;
      end else if (ev_leaf_rsp) phys_addr <= frame_join(mem_rdata, lin_q);
    end
  end

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_fault_needs_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done);
  p_fault_no_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (phys_addr == '0) && (fault_code == FAULT_VEC));
  p_bypass_echo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bypass |=> done && !fault && (phys_addr == $past(req_lin)));
  p_root_fault_lvl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_root_rsp && !rsp_ok |=> fault && !fault_level && (fault_lin == lin_q));
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter logic [7:0] FAULT_VEC = 8'h0E
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_lin,
  input  logic [31:0] dir_base,
  input  logic        pg_en,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        done,
  output logic [31:0] phys_addr,
  output logic        fault,
  output logic [7:0]  fault_code,
  output logic        fault_level,
  output logic [31:0] fault_lin
);
  walk_st_t st;
  logic ev_accept, ev_bypass, ev_root_rsp, ev_leaf_rsp;

  assign req_ready = (st == ST_IDLE);
  assign mem_req   = (st != ST_IDLE);

  pgwalk_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .pg_en(pg_en),
    .mem_rvalid(mem_rvalid), .rsp_present(ent_present(mem_rdata)),
    .st(st), .ev_accept(ev_accept), .ev_bypass(ev_bypass),
    .ev_root_rsp(ev_root_rsp), .ev_leaf_rsp(ev_leaf_rsp)
  );

  pgwalk_dpath #(.FAULT_VEC(FAULT_VEC)) u_dpath (
    .clk(clk), .rst_n(rst_n), .st(st), .ev_accept(ev_accept),
    .ev_bypass(ev_bypass), .ev_root_rsp(ev_root_rsp), .ev_leaf_rsp(ev_leaf_rsp),
    .req_lin(req_lin), .dir_base(dir_base), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .done(done), .phys_addr(phys_addr), .fault(fault),
    .fault_code(fault_code), .fault_level(fault_level), .fault_lin(fault_lin)
  );

  p_hold_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && $past(mem_req) && !$past(mem_rvalid) |-> $stable(mem_addr));
  p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);
endmodule

// File: tb/pgwalk_top_tb.sv
module pgwalk_top_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, pg_en = 1'b0, mem_rvalid;
  logic [31:0] req_lin = '0, dir_base = '0, mem_rdata;
  logic req_ready, mem_req, done, fault, fault_level;
  logic [31:0] mem_addr, phys_addr, fault_lin;
  logic [7:0] fault_code;

  int n_vec = 0, n_bad = 0, lat = 1, cnt = 0;
  bit finished = 0;
  logic [31:0] mem [logic [31:0]];

  always #2 clk = ~clk;

  pgwalk_top u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_lin(req_lin), .dir_base(dir_base), .pg_en(pg_en), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .done(done), .phys_addr(phys_addr), .fault(fault), .fault_code(fault_code),
    .fault_level(fault_level), .fault_lin(fault_lin)
  );

  function automatic logic [31:0] rd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // behavioural memory: answers a held read after lat cycles
  always @(posedge clk) begin
    if (!rst_n) begin mem_rvalid <= 1'b0; mem_rdata <= '0; cnt <= 0; end
    else if (mem_req && !mem_rvalid) begin
      if (cnt == lat - 1) begin mem_rvalid <= 1'b1; mem_rdata <= rd(mem_addr); cnt <= 0; end
      else cnt <= cnt + 1;
    end else mem_rvalid <= 1'b0;
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference: expected outcome from arithmetic, then cycle-by-cycle compare
  task automatic walk(logic [31:0] lin, logic [31:0] base, bit en, int l);
    logic [31:0] ra, ta, pde, pte, ephys;
    int k, lvl;
    bit efault;
    ra = (base & 32'hFFFF_F000) + ((lin >> 22) * 4);
    pde = rd(ra);
    ta = (pde & 32'hFFFF_F000) + (((lin >> 12) & 32'h3FF) * 4);
    pte = rd(ta);
    efault = 0; lvl = 0; ephys = 0;
    if (!en) begin k = 0; ephys = lin; end
    else if (pde[0] == 1'b0) begin k = l + 1; efault = 1; lvl = 0; end
    else if (pte[0] == 1'b0) begin k = 2*l + 2; efault = 1; lvl = 1; end
    else begin k = 2*l + 2; ephys = (pte & 32'hFFFF_F000) | (lin & 32'hFFF); end
    lat = l;
    @(negedge clk);
    req_valid = 1'b1; req_lin = lin; dir_base = base; pg_en = en;
    @(posedge clk);
    @(negedge clk);
    // R9: scramble the captured inputs for the rest of the walk
    req_valid = 1'b0; req_lin = ~lin; dir_base = ~base; pg_en = ~en;
    for (int j = 0; j <= k + 1; j++) begin
      bit ereq;
      logic [31:0] eaddr;
      ereq = en && (j < k);
      eaddr = (j <= l) ? ra : ta;
      chk(done == (j == k), "R8 done pulse", {31'b0, done}, {31'b0, j == k});
      chk(mem_req == ereq, en ? "R10 read hold" : "R2 no read", {31'b0, mem_req}, {31'b0, ereq});
      chk(req_ready == !ereq, "R8 ready", {31'b0, req_ready}, {31'b0, !ereq});
      if (ereq) chk(mem_addr == eaddr, (j <= l) ? "R3 root addr" : "R4 leaf addr", mem_addr, eaddr);
      if (j == k) begin
        chk(phys_addr == ephys, efault ? "R6/R7 no addr" : (en ? "R5 phys R9" : "R2 bypass"), phys_addr, ephys);
        chk(fault == efault, "R6 fault flag", {31'b0, fault}, {31'b0, efault});
        chk(fault_code == (efault ? 8'h0E : 8'h00), "R7 code", {24'b0, fault_code}, efault ? 32'hE : 32'h0);
        if (efault) begin
          chk(fault_level == lvl[0], lvl ? "R7 level" : "R6 level", {31'b0, fault_level}, lvl);
          chk(fault_lin == lin, "R6 fault lin", fault_lin, lin);
        end
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    mem[32'h0001_0004] = 32'h0002_0001;
    mem[32'h0002_000C] = 32'h0ABC_D007;
    mem[32'h0001_0FFC] = 32'h0003_0F63;
    mem[32'h0003_0004] = 32'h1234_5FFF;
    mem[32'h0001_0008] = 32'h0004_0FFE;   // root absent (bit 0 clear)
    repeat (3) @(negedge clk);
    chk(!done && !fault && !mem_req && req_ready, "R1 in reset", {28'b0, done, fault, mem_req, req_ready}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !fault && !mem_req && req_ready, "R1 after reset", {28'b0, done, fault, mem_req, req_ready}, 32'h1);
    walk(32'h1234_5678, 32'h0001_0000, 1'b0, 1);   // R2 bypass
    walk(32'h0040_3ABC, 32'h0001_0123, 1'b1, 1);   // R3 R4 R5
    walk(32'hFFC0_1234, 32'h0001_0000, 1'b1, 3);   // R5 top index, R10
    walk(32'h0080_0000, 32'h0001_0000, 1'b1, 2);   // R6 absent root
    walk(32'h0000_0000, 32'h0001_0000, 1'b1, 1);   // R6 missing root
    walk(32'h0040_5FFF, 32'h0001_0000, 1'b1, 2);   // R7 absent leaf
    walk(32'h0040_3001, 32'h0001_0000, 1'b1, 5);   // R10 long latency
    walk(32'hDEAD_BEEF, 32'h0000_0000, 1'b0, 4);   // R2 again
    walk(32'hFFC0_1FFF, 32'h0001_0000, 1'b1, 1);   // R5 back to back
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule